// File: doc/BRIEF.md
# Serial Flash Register Transfer Engine

This block lets software run a serial NOR flash through a handful of word registers on a simple memory-mapped slave bus. Software first writes the control word. That write drives the two active-low device selects and picks how many bytes, from one to four, each data access moves. Each write of the data word then shifts that many bytes out on a single serial lane, starting with bit 31. Each read of the data word returns the bytes captured by the previous transfer and starts a new receive of the programmed length. During a receive the engine shifts out zeros. A select stays low across any number of data accesses. A flash command is therefore built in pieces: the opcode, then the address, then the data. The select rises only when software rewrites the control word with that bit high.

The serial clock idles low. The outgoing bit changes on the falling edge and the incoming bit is sampled on the rising edge. The half period of the serial clock is set in the configuration word. After a select is released, the engine holds off all traffic for a programmable number of divider periods.

A four-state machine sequences the engine:
- ST_IDLE goes to ST_LOW when a data access is accepted.
- ST_LOW goes to ST_HIGH on each divider tick, which is the rising edge.
- ST_HIGH goes back to ST_LOW on a tick while bits remain, which is the falling edge.
- ST_HIGH goes to ST_IDLE on the tick of the last bit.
- ST_IDLE goes to ST_GAP when a control write raises a select that was low.
- ST_GAP goes to ST_IDLE after (hold+1) ticks.

Top module: `sflash_xfer`

## Requirements
- R1: After reset both device selects are high, the serial clock and the output line are low, the control word reads 0xC800_0000 and the configuration word reads 0.
- R2: The bus address is a word index. Index 0 is configuration, with the divider in bits 31:29 and the select hold time in bits 26:23; all its other bits read 0. Indices 1 and 4 are plain 32-bit read/write words. Index 2 is the control word and index 3 is the data word. Indices 5 to 7 read 0.
- R3: Control word layout: bit 31 is the active-low select of device 0 and drives `spi_cs_n[0]`. Bit 30 is the same for device 1 and drives `spi_cs_n[1]`. Bits 29:28 hold the byte count minus one. Bit 27 is a read-only ready flag. Bits 26:25 (lane-width code) and bit 24 (target) are stored and read back. Bits 23:0 read 0.
- R4: A data write shifts (count) bytes out most significant bit first, starting at bit 31. The serial clock idles low, and the output line changes only while the clock is low.
- R5: Each serial clock phase lasts (divider+1) system clock cycles.
- R6: The ready flag reads 0 from the cycle after a data access is accepted until the final bit completes, which is 2·8·(count)·(divider+1) edges later.
- R7: A data read returns the bytes captured by the previous transfer and starts a receive of (count) bytes that shifts out zeros. Captured bytes sit at the top of the word, first byte in bits 31:24, and unused low bytes read 0.
- R8: A select stays low across successive data accesses and across control writes that keep it low, so both directions of one flash command form a single continuous byte stream.
- R9: A control write that raises a select that was low holds the ready flag at 0 for (hold+1)·(divider+1) cycles.
- R10: While the ready flag is 0, writes to the configuration, control and data words are ignored, and data reads start nothing.
- R11: A 3-byte address is sent by writing it shifted left by 8 with byte-count code 2. A 4-byte address is sent unshifted with code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write access, 0 for a read access |
| bus_addr | input | 3 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, same cycle |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 2 | Active-low device selects |

## Verification
Two events can land on the same clock edge. One is a bus access arriving as the machine leaves ST_HIGH after its last bit, or leaves ST_GAP. The other is the machine returning to ST_IDLE on that edge. The bench counts cycles from the accepted access and places a control write exactly on the final busy edge; the write must leave no trace. The next read must then show the ready flag high. The release hold time is bracketed the same way: one read lands on the last held cycle and one lands on the first free cycle.

// File: rtl/sflash_pkg.sv
package sflash_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_GAP
    } xfer_state_t;

    localparam logic [2:0] REG_CFG   = 3'd0;
    localparam logic [2:0] REG_MMCFG = 3'd1;
    localparam logic [2:0] REG_CTL   = 3'd2;
    localparam logic [2:0] REG_DATA  = 3'd3;
    localparam logic [2:0] REG_DATA2 = 3'd4;
endpackage

// File: rtl/sflash_clkdiv.sv
module sflash_clkdiv #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sflash_shifter.sv
module sflash_shifter #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_val,
    input  logic              shift_en,
    input  logic              shift_in,
    output logic [WORD_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift_en) begin
            q <= {q[WORD_W-2:0], shift_in};
        end
    end
endmodule

// File: rtl/sflash_xfer.sv
module sflash_xfer
    import sflash_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int DIV_W   = 3,
    parameter int TCS_W   = 4,
    parameter int TCS_LSB = 23,
    parameter int ADDR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [1:0]        spi_cs_n
);
    localparam int CNT_W   = $clog2(WORD_W + 1);
    localparam int TOP     = WORD_W - 1;
    localparam int DIV_LSB = WORD_W - DIV_W;

    xfer_state_t state_q, state_d;

    logic [DIV_W-1:0]  div_q;
    logic [TCS_W-1:0]  tcs_q, gcnt_q;
    logic [WORD_W-1:0] mmcfg_q, data2_q, data_q;
    logic [1:0]        csb_q, csb_new, len_q, iow_q;
    logic              tsel_q, rx_bit_q, tick, ready;
    logic [CNT_W-1:0]  bitcnt_q, nbits;
    logic [WORD_W-1:0] sreg, shifted, aligned, ctl_word;
    logic              wr_ok, start_wr, start_rd, start, release_sel, last_bit;

    // bus decode
    assign ready       = (state_q == ST_IDLE);
    assign wr_ok       = bus_sel && bus_wr && ready;
    assign start_wr    = wr_ok && (bus_addr == REG_DATA);
    assign start_rd    = bus_sel && !bus_wr && ready && (bus_addr == REG_DATA);
    assign start       = start_wr || start_rd;
    assign csb_new     = {bus_wdata[TOP-1], bus_wdata[TOP]};
    assign release_sel = wr_ok && (bus_addr == REG_CTL) && |(csb_new & ~csb_q);

    assign nbits    = CNT_W'((int'(len_q) + 1) * 8);
    assign last_bit = (bitcnt_q == nbits - 1'b1);
    assign shifted  = {sreg[WORD_W-2:0], rx_bit_q};
    assign aligned  = shifted << (CNT_W'(WORD_W) - nbits);

    sflash_clkdiv #(.DIV_W(DIV_W)) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q != ST_IDLE),
        .div   (div_q),
        .tick  (tick)
    );

    sflash_shifter #(.WORD_W(WORD_W)) i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val (start_wr ? bus_wdata : '0),
        .shift_en ((state_q == ST_HIGH) && tick),
        .shift_in (rx_bit_q),
        .q        (sreg)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start)            state_d = ST_LOW;
                else if (release_sel) state_d = ST_GAP;
            end
            ST_LOW:  if (tick) state_d = ST_HIGH;
            ST_HIGH: if (tick) state_d = last_bit ? ST_IDLE : ST_LOW;
            ST_GAP:  if (tick && (gcnt_q == tcs_q)) state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        spi_sclk = (state_q == ST_HIGH);
        spi_mosi = ((state_q == ST_LOW) || (state_q == ST_HIGH)) && sreg[TOP];
        spi_cs_n = csb_q;
    end

    // registers and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q    <= '0;
            tcs_q    <= '0;
            mmcfg_q  <= '0;
            data2_q  <= '0;
            data_q   <= '0;
            csb_q    <= 2'b11;
            len_q    <= '0;
            iow_q    <= '0;
            tsel_q   <= 1'b0;
            bitcnt_q <= '0;
            gcnt_q   <= '0;
            rx_bit_q <= 1'b0;
        end else begin
            if (wr_ok) begin
                unique case (bus_addr)
                    REG_CFG: begin
                        div_q <= bus_wdata[DIV_LSB +: DIV_W];
                        tcs_q <= bus_wdata[TCS_LSB +: TCS_W];
                    end
                    REG_MMCFG: mmcfg_q <= bus_wdata;
                    REG_CTL: begin
                        csb_q  <= csb_new;
                        len_q  <= bus_wdata[TOP-2 -: 2];
                        iow_q  <= bus_wdata[TOP-5 -: 2];
                        tsel_q <= bus_wdata[TOP-7];
                    end
                    REG_DATA2: data2_q <= bus_wdata;
                    default: ;
                endcase
            end
            if (state_q == ST_IDLE) bitcnt_q <= '0;
            else if ((state_q == ST_HIGH) && tick) bitcnt_q <= bitcnt_q + 1'b1;
            if (state_q != ST_GAP) gcnt_q <= '0;
            else if (tick) gcnt_q <= gcnt_q + 1'b1;
            if ((state_q == ST_LOW) && tick) rx_bit_q <= spi_miso;
            if ((state_q == ST_HIGH) && tick && last_bit) data_q <= aligned;
        end
    end

    // read mux
    always_comb begin
        ctl_word          = '0;
        ctl_word[TOP]     = csb_q[0];
        ctl_word[TOP-1]   = csb_q[1];
        ctl_word[TOP-2 -: 2] = len_q;
        ctl_word[TOP-4]   = ready;
        ctl_word[TOP-5 -: 2] = iow_q;
        ctl_word[TOP-7]   = tsel_q;
        bus_rdata = '0;
        unique case (bus_addr)
            REG_CFG: begin
                bus_rdata[DIV_LSB +: DIV_W] = div_q;
                bus_rdata[TCS_LSB +: TCS_W] = tcs_q;
            end
            REG_MMCFG: bus_rdata = mmcfg_q;
            REG_CTL:   bus_rdata = ctl_word;
            REG_DATA:  bus_rdata = data_q;
            REG_DATA2: bus_rdata = data2_q;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sflash_xfer_chk.sv
module sflash_xfer_chk
    import sflash_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              spi_sclk,
    input logic              spi_mosi,
    input logic [1:0]        spi_cs_n,
    input logic              ready,
    input logic [WORD_W-1:0] ctl_word
);
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !spi_sclk);                                          // R4
    AST_MOSI_HOLD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sclk) |-> $stable(spi_mosi));                        // R4
    AST_START_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && bus_sel && (bus_addr == REG_DATA)) |=> !ready);      // R6
    AST_CS_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(spi_cs_n));                                 // R10
    AST_CTL_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && bus_sel && bus_wr) |=>
            ($stable(ctl_word[31:28]) && $stable(ctl_word[26:24])));   // R10
endmodule

bind sflash_xfer sflash_xfer_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .spi_sclk (spi_sclk),
    .spi_mosi (spi_mosi),
    .spi_cs_n (spi_cs_n),
    .ready    (ready),
    .ctl_word (ctl_word)
);

// File: tb/test_sflash_xfer.sv
module test_sflash_xfer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_sel = 1'b0, b_wr = 1'b0;
    logic [2:0]  b_addr = '0;
    logic [31:0] b_wdata = '0, b_rdata;
    logic        spi_sclk, spi_mosi, flash_miso;
    logic [1:0]  spi_cs_n;
    int          n_chk = 0, n_err = 0;

    always #4 clk = ~clk;

    sflash_xfer i_sflash_xfer (
        .clk(clk), .rst_n(rst_n), .bus_sel(b_sel), .bus_wr(b_wr), .bus_addr(b_addr),
        .bus_wdata(b_wdata), .bus_rdata(b_rdata), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(flash_miso), .spi_cs_n(spi_cs_n)
    );

    // behavioural flash on select 0: logs received bytes, answers 0x90+k for byte k
    logic [7:0] log_b [16];
    logic [7:0] rx_sh = '0, cur_b;
    int         log_n = 0, bit_n = 0, fall_n = 0;
    logic       prev_sclk = 1'b0;
    logic [1:0] prev_cs = 2'b11;

    always @(spi_sclk or spi_cs_n) begin
        if (prev_cs[0] && !spi_cs_n[0]) begin
            log_n = 0; bit_n = 0; fall_n = 0;
        end else if (!spi_cs_n[0]) begin
            if (spi_sclk && !prev_sclk) begin
                rx_sh = {rx_sh[6:0], spi_mosi};
                bit_n++;
                if (bit_n % 8 == 0 && log_n < 16) begin
                    log_b[log_n] = rx_sh;
                    log_n++;
                end
            end else if (!spi_sclk && prev_sclk) begin
                fall_n++;
            end
        end
        prev_sclk = spi_sclk;
        prev_cs   = spi_cs_n;
    end

    always_comb begin
        cur_b      = 8'(8'h90 + fall_n / 8);
        flash_miso = spi_cs_n[0] ? 1'b0 : cur_b[3'(7 - fall_n % 8)];
    end

    localparam logic [33:0] VEC [4] = '{
        {2'd0, 32'hA500_0000},
        {2'd1, 32'h3C5A_0000},
        {2'd2, 32'hABCD_EF00},
        {2'd3, 32'hDEAD_BEEF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // bus tasks: called at a negedge, access sampled at the next posedge
    task automatic bwr(input logic [2:0] a, input logic [31:0] d);
        b_sel = 1'b1; b_wr = 1'b1; b_addr = a; b_wdata = d;
        @(negedge clk);
        b_sel = 1'b0; b_wr = 1'b0;
    endtask

    task automatic brd(input logic [2:0] a, output logic [31:0] d);
        b_sel = 1'b1; b_wr = 1'b0; b_addr = a;
        #2 d = b_rdata;
        @(negedge clk);
        b_sel = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        int n = 0;
        do begin
            brd(3'd2, v);
            n++;
        end while (!v[27] && n < 5000);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        logic [31:0] rd, expw;
        logic [1:0]  ln;
        int          nb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 cs_n", {30'd0, spi_cs_n}, 32'h3);
        check("R1 sclk/mosi", {30'd0, spi_sclk, spi_mosi}, 32'h0);
        brd(3'd2, rd); check("R1 ctl", rd, 32'hC800_0000);
        brd(3'd0, rd); check("R1 cfg", rd, 32'h0);

        // R2 decode
        bwr(3'd1, 32'hDEAD_BEEF); brd(3'd1, rd); check("R2 idx1", rd, 32'hDEAD_BEEF);
        bwr(3'd4, 32'h1234_5678); brd(3'd4, rd); check("R2 idx4", rd, 32'h1234_5678);
        bwr(3'd0, 32'hFFFF_FFFF); brd(3'd0, rd); check("R2 cfg mask", rd, 32'hE780_0000);
        bwr(3'd5, 32'hFFFF_FFFF); brd(3'd5, rd); check("R2 unmapped", rd, 32'h0);
        bwr(3'd0, 32'h0);

        // R4 R7 table walk: write L bytes, read back capture, read shifts zeros
        for (int v = 0; v < 4; v++) begin
            ln = VEC[v][33:32];
            nb = int'(ln) + 1;
            bwr(3'd2, {2'b01, ln, 28'd0});
            bwr(3'd3, VEC[v][31:0]);
            wait_idle();
            brd(3'd3, rd);
            expw = '0;
            for (int i = 0; i < nb; i++) expw[31-8*i -: 8] = 8'(8'h90 + i);
            check("R7 capture", rd, expw);
            wait_idle();
            check("R4 byte count", log_n, 2 * nb);
            for (int i = 0; i < nb; i++) begin
                check("R4 mosi byte", {24'd0, log_b[i]}, {24'd0, VEC[v][31-8*i -: 8]});
                check("R7 zero fill", {24'd0, log_b[nb+i]}, 32'h0);
            end
            bwr(3'd2, {2'b11, ln, 28'd0});
            wait_idle();
        end

        // R3 control fields and pins
        bwr(3'd2, 32'h8300_00FF);
        brd(3'd2, rd); check("R3 ctl read", rd, 32'h8B00_0000);
        check("R3 cs pins", {30'd0, spi_cs_n}, 32'h1);
        bwr(3'd2, 32'hC000_0000);
        wait_idle();

        // R11 R8 3-byte address command, stream continues across pieces
        bwr(3'd2, 32'h4000_0000);
        bwr(3'd3, 32'h0B00_0000); wait_idle();
        bwr(3'd2, 32'h6000_0000);
        check("R8 cs held", {31'd0, spi_cs_n[0]}, 32'h0);
        bwr(3'd3, 32'h1234_5600); wait_idle();
        bwr(3'd2, 32'h7000_0000);
        brd(3'd3, rd); check("R8 addr-phase capture", rd, 32'h9192_9300);
        wait_idle();
        brd(3'd3, rd); check("R8 continuous read", rd, 32'h9495_9697);
        wait_idle();
        check("R11 cmd", {24'd0, log_b[0]}, 32'h0B);
        check("R11 addr3", {log_b[1], log_b[2], log_b[3], 8'd0}, 32'h1234_5600);
        bwr(3'd2, 32'hC000_0000); wait_idle();

        // R11 4-byte address
        bwr(3'd2, 32'h4000_0000);
        bwr(3'd3, 32'h1300_0000); wait_idle();
        bwr(3'd2, 32'h7000_0000);
        bwr(3'd3, 32'h89AB_CDEF); wait_idle();
        check("R11 count4", log_n, 5);
        check("R11 addr4", {log_b[1], log_b[2], log_b[3], log_b[4]}, 32'h89AB_CDEF);
        bwr(3'd2, 32'hC000_0000); wait_idle();

        // R5 phase length with divider 2
        bwr(3'd0, 32'h4000_0000);
        bwr(3'd2, 32'h4000_0000);
        bwr(3'd3, 32'h8000_0000);
        check("R5 low start", {30'd0, spi_sclk, spi_mosi}, 32'h1);
        repeat (2) @(negedge clk); check("R5 low end", {31'd0, spi_sclk}, 32'h0);
        @(negedge clk);            check("R5 high start", {31'd0, spi_sclk}, 32'h1);
        repeat (2) @(negedge clk); check("R5 high end", {31'd0, spi_sclk}, 32'h1);
        @(negedge clk);
        check("R4 second bit", {30'd0, spi_sclk, spi_mosi}, 32'h0);
        wait_idle();

        // R6 R10 write landing on the final busy edge (div 1, 1 byte: 32 edges)
        bwr(3'd0, 32'h2000_0000);
        bwr(3'd3, 32'h5A00_0000);
        brd(3'd2, rd); check("R6 busy after start", {31'd0, rd[27]}, 32'h0);
        bwr(3'd0, 32'hE000_0000);
        repeat (29) @(negedge clk);
        bwr(3'd2, 32'h7000_0000);
        brd(3'd2, rd); check("R10 late ctl write ignored", rd, 32'h4800_0000);
        brd(3'd0, rd); check("R10 busy cfg write ignored", rd, 32'h2000_0000);

        // R9 release hold: hold 2, div 1 -> 6 cycles
        bwr(3'd0, 32'h2100_0000);
        bwr(3'd2, 32'hC000_0000);
        repeat (5) @(negedge clk);
        brd(3'd2, rd); check("R9 last held cycle", rd, 32'hC000_0000);
        brd(3'd2, rd); check("R9 first free cycle", rd, 32'hC800_0000);

        summary();
    end
endmodule